// File: doc/BRIEF.md
# I2C Target Byte Engine

This block is the target (slave) side of a two-wire serial bus. It watches the clock and data lines through synchronizers running on the system clock. From those samples it detects bus start and stop conditions. It collects the 8-bit calling word, which is a 7-bit address followed by a direction bit. If the address equals the configured value, it acknowledges and then moves data bytes in the direction the master asked for. Received bytes appear on a byte-wide port with a one-cycle valid strobe. Bytes to send are requested from the host with a one-cycle request strobe.

The data line is driven open-drain only. The single output `sda_oe` means "pull the line low", and external logic combines it with the other bus drivers. A start condition seen at any point, including in the middle of a byte, throws away the current transfer and begins a new address phase. A stop condition releases the line and idles the engine. Clock stretching, general call and extended addressing are not provided.

Top module: `i2c_tgt_engine`

## Requirements
- R1: While reset is applied and right after it, `sda_oe`, `rx_valid` and `tx_req` are all 0.
- R2: If the 7 address bits of the calling word (first bit on the wire is the address MSB, and the eighth bit is the direction, 0 = master writes, 1 = master reads) equal `own_addr`, the engine pulls SDA low for the whole ninth clock.
- R3: If the address does not match, the engine never pulls SDA and produces no `rx_valid` or `tx_req` until the next start or stop.
- R4: In a write, each byte is assembled MSB first from SDA sampled on rising SCL. After the eighth bit, the byte is placed on `rx_data` together with a `rx_valid` pulse.
- R5: In a write, the engine acknowledges a data byte (SDA low at the ninth clock) when `rx_refuse` is 0. When `rx_refuse` is 1, it leaves SDA released.
- R6: In a read, `tx_req` pulses once when the address is acknowledged. `tx_data` is taken at the falling SCL edge that ends the acknowledge clock and is sent MSB first.
- R7: In a read, an acknowledge from the master (SDA low at the ninth clock) produces another `tx_req`, and the next byte is sent. A not-acknowledge makes the engine release SDA and stay silent until a start or stop.
- R8: A start condition during any phase, including mid-byte, restarts address reception. The new calling word may select either direction.
- R9: A stop condition releases SDA. Clock pulses that follow without a new start produce no drive and no `rx_valid`.
- R10: `sda_oe` changes only after a detected falling SCL edge, or on a start or stop, so it never changes while SCL is high during a data bit.
- R11: `rx_valid` and `tx_req` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | ADDR_W (7) | Address this target answers to |
| rx_refuse | input | 1 | 1 = do not acknowledge received data bytes |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull the data line low |
| rx_data | output | DATA_W (8) | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` is new |
| tx_data | input | DATA_W (8) | Next byte to send to the master |
| tx_req | output | 1 | One-cycle strobe: provide the next `tx_data` |

## Verification
The bench builds the engine with its defaults: two synchronizer stages, a 7-bit address and 8-bit data. With those values the calling word decodes in the standard layout. The latency from bus edge to response is then three to four system cycles, well inside the bench's bus quarter-period. That makes the timing-sensitive cases reachable and deterministic: the change of direction on repeated start, a start in the middle of a byte, and the master not-acknowledge path. The same holds for the acknowledge slot and for release on stop.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,   // bus free or after stop
      ST_ADDR,   // shifting calling word
      ST_AACK,   // address acknowledge slot
      ST_RX,     // receiving data bits
      ST_RACK,   // our acknowledge of a received byte
      ST_TX,     // sending data bits
      ST_TACK,   // master acknowledge slot
      ST_SKIP    // not addressed or finished, wait for start/stop
   } tgt_state_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("i2c_tgt_sync: STAGES must be 0..4");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '1;   // idle bus lines read high
            end else begin
               q[0] <= d_in;
               for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
            end
         end
         assign d_out = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);

   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_d;
   assign scl_fall  = ~scl_s &  scl_d;
   // data edges only count as conditions while the clock stays high
   assign start_evt = scl_s & scl_d &  sda_d & ~sda_s;
   assign stop_evt  = scl_s & scl_d & ~sda_d &  sda_s;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              rx_refuse,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_req
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

   if (DATA_W != 8) begin : g_bad_data
      $error("i2c_tgt_engine: DATA_W must be 8");
   end
   if (ADDR_W != DATA_W - 1) begin : g_bad_addr
      $error("i2c_tgt_engine: ADDR_W must be DATA_W-1");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_evt, stop_evt;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_in(scl_in), .d_out(scl_s));
   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_in(sda_in), .d_out(sda_s));

   i2c_tgt_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt));

   tgt_state_t        state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic              more;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         more     <= 1'b0;
         sda_oe   <= 1'b0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
         tx_req   <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         tx_req   <= 1'b0;
         if (start_evt) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (stop_evt) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_RX: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[DATA_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == LAST_BIT) begin
                     if (state == ST_RX) begin
                        rx_data  <= shreg;
                        rx_valid <= 1'b1;
                        sda_oe   <= ~rx_refuse;
                        state    <= ST_RACK;
                     end else if (shreg[DATA_W-1:1] == own_addr) begin
                        sda_oe <= 1'b1;
                        more   <= shreg[0];     // direction bit: 1 = read
                        tx_req <= shreg[0];
                        state  <= ST_AACK;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_AACK, ST_RACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (state == ST_AACK && more) begin
                        sda_oe <= ~tx_data[DATA_W-1];
                        shreg  <= {tx_data[DATA_W-2:0], 1'b0};
                        state  <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bit_cnt == LAST_BIT) begin
                        sda_oe <= 1'b0;          // let master answer
                        more   <= 1'b0;
                        state  <= ST_TACK;
                     end else begin
                        sda_oe <= ~shreg[DATA_W-1];
                        shreg  <= {shreg[DATA_W-2:0], 1'b0};
                     end
                  end
               end
               ST_TACK: begin
                  if (scl_rise) begin
                     if (sda_s) begin
                        state <= ST_SKIP;        // end of data from master
                     end else begin
                        more   <= 1'b1;
                        tx_req <= 1'b1;
                     end
                  end else if (scl_fall && more) begin
                     bit_cnt <= '0;
                     sda_oe  <= ~tx_data[DATA_W-1];
                     shreg   <= {tx_data[DATA_W-2:0], 1'b0};
                     state   <= ST_TX;
                  end
               end
               default: ;                        // ST_IDLE, ST_SKIP wait
            endcase
         end
      end
   end

   a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe);

   a_r8_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> state == ST_ADDR);

   a_r10_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> $past(scl_fall | start_evt | stop_evt));

   a_r11_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   a_r11_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |=> !tx_req);

   a_r3_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP || state == ST_IDLE) |-> !sda_oe);

endmodule

// File: tb/sim_i2c_tgt_engine.sv
module sim_i2c_tgt_engine;

   localparam int HQ = 12;        // system cycles per bus quarter-bit
   localparam logic [6:0] MY_ADDR = 7'h2A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic rx_refuse = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic sda_oe, rx_valid, tx_req;
   logic [7:0] rx_data;
   wire  sda_line = sda_m & ~sda_oe;

   int checks = 0;
   int errors = 0;
   int rx_cnt = 0;
   int tx_cnt = 0;
   int oe_cycles = 0;
   int hi_changes = 0;
   int long_pulse = 0;
   logic [7:0] last_rx = 8'h00;
   logic prev_oe = 1'b0, prev_rxv = 1'b0, prev_txr = 1'b0;

   always #4 clk = ~clk;   // 8 ns period

   i2c_tgt_engine u0 (
      .clk(clk), .rst_n(rst_n), .own_addr(MY_ADDR), .rx_refuse(rx_refuse),
      .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
      .rx_data(rx_data), .rx_valid(rx_valid),
      .tx_data(tx_data), .tx_req(tx_req));

   // passive monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rx_valid) begin rx_cnt++; last_rx = rx_data; end
      if (tx_req) tx_cnt++;
      if (sda_oe) oe_cycles++;
      if (rst_n && sda_oe != prev_oe && scl_m) hi_changes++;
      if ((rx_valid && prev_rxv) || (tx_req && prev_txr)) long_pulse++;
      prev_oe = sda_oe; prev_rxv = rx_valid; prev_txr = tx_req;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (HQ) @(negedge clk);
   endtask

   task automatic bus_bit(input logic b, output logic r);
      sda_m = b; wq();
      scl_m = 1'b1; wq();
      r = sda_line; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic gen_start();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic gen_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) bus_bit(v[i], r);
      bus_bit(1'b1, ack);
   endtask

   task automatic read_byte(output logic [7:0] v, input logic m_ack,
                            input logic [7:0] next_tx);
      logic r, d;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b1, r);
         v[i] = r;
         if (i == 7) tx_data = next_tx;
      end
      bus_bit(~m_ack, d);
   endtask

   task automatic t_reset();
      chk("R1 sda_oe", sda_oe, 0);
      chk("R1 rx_valid", rx_valid, 0);
      chk("R1 tx_req", tx_req, 0);
   endtask

   task automatic t_write();
      logic a; int n0;
      n0 = rx_cnt;
      gen_start();
      send_byte({MY_ADDR, 1'b0}, a);
      chk("R2 addr ack", a, 0);
      send_byte(8'hA5, a);
      chk("R5 data ack", a, 0);
      chk("R4 rx byte", last_rx, 8'hA5);
      rx_refuse = 1'b1;
      send_byte(8'h3C, a);
      chk("R5 refused ack", a, 1);
      chk("R4 rx byte 2", last_rx, 8'h3C);
      chk("R4 rx count", rx_cnt - n0, 2);
      rx_refuse = 1'b0;
      gen_stop();
   endtask

   task automatic t_mismatch();
      logic a; int n0, t0, o0;
      n0 = rx_cnt; t0 = tx_cnt; o0 = oe_cycles;
      gen_start();
      send_byte({7'h15, 1'b0}, a);
      chk("R3 no ack", a, 1);
      send_byte(8'h00, a);
      chk("R3 data ignored", a, 1);
      chk("R3 no rx_valid", rx_cnt - n0, 0);
      chk("R3 never drives", oe_cycles - o0, 0);
      send_byte({7'h2A ^ 7'h40, 1'b1}, a);
      chk("R3 no tx_req", tx_cnt - t0, 0);
      gen_start();
      send_byte({MY_ADDR, 1'b0}, a);
      chk("R3 R8 ack after restart", a, 0);
      gen_stop();
   endtask

   task automatic t_read();
      logic a, r; logic [7:0] v; int t0, o0;
      t0 = tx_cnt;
      tx_data = 8'hC3;
      gen_start();
      send_byte({MY_ADDR, 1'b1}, a);
      chk("R2 read addr ack", a, 0);
      chk("R6 first tx_req", tx_cnt - t0, 1);
      read_byte(v, 1'b1, 8'h5E);
      chk("R6 tx byte", v, 8'hC3);
      chk("R7 tx_req after ack", tx_cnt - t0, 2);
      read_byte(v, 1'b0, 8'hFF);
      chk("R7 second byte", v, 8'h5E);
      chk("R7 no req after nack", tx_cnt - t0, 2);
      o0 = oe_cycles;
      for (int i = 0; i < 9; i++) bus_bit(1'b1, r);
      chk("R7 silent after nack", oe_cycles - o0, 0);
      gen_stop();
   endtask

   task automatic t_restart_mid();
      logic a, r; logic [7:0] v;
      gen_start();
      send_byte({MY_ADDR, 1'b0}, a);
      for (int i = 0; i < 4; i++) bus_bit(i[0], r);
      tx_data = 8'h96;
      gen_start();
      send_byte({MY_ADDR, 1'b1}, a);
      chk("R8 mid-byte restart ack", a, 0);
      read_byte(v, 1'b0, 8'h00);
      chk("R8 direction switch", v, 8'h96);
      gen_stop();
   endtask

   task automatic t_stop();
      logic a, r; int n0, o0;
      gen_start();
      send_byte({MY_ADDR, 1'b0}, a);
      send_byte(8'h11, a);
      chk("R9 ack before stop", a, 0);
      gen_stop();
      chk("R9 released", sda_oe, 0);
      n0 = rx_cnt; o0 = oe_cycles;
      scl_m = 1'b0; wq();
      for (int i = 0; i < 18; i++) bus_bit(1'b0, r);
      chk("R9 no rx after stop", rx_cnt - n0, 0);
      chk("R9 no drive after stop", oe_cycles - o0, 0);
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write();
      t_mismatch();
      t_read();
      t_restart_mid();
      t_stop();
      chk("R10 no change while SCL high", hi_changes, 0);
      chk("R11 single-cycle strobes", long_pulse, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule